// File: doc/BRIEF.md
# Bidirectional Reset Pin Controller

This block looks after a shared, active-low, open-drain reset line. Any device on the board may pull the line low to ask for a system reset. The controller also pulls the same line itself to hold every device in reset for a guaranteed length of time. The line level is read back through a synchronizer. A request counts only after the line has stayed low for a minimum number of clock cycles.

When a request is accepted, the controller does not enter reset at once if a bus transfer is in flight. It waits until the bus reports idle, or until a bus-watchdog interval expires, so that a write in progress is not cut short. It then raises the internal reset and an output-enable kill. The kill line lets the pad logic float general-purpose pins as inputs and park bus strobes at their inactive levels.

The controller waits for the external source to let go of the line. It then pulls the line low itself for a fixed number of cycles and returns to idle, which ends the reset.

Top module: `rstpin_ctrl`

## Requirements
- R1: During and directly after the power-on reset input `rst_n`, the internal reset, the kill line and the pull-down enable are all low.
- R2: The line counts as requesting reset while `rst_pin_i` reads 0. A low that lasts fewer than MIN_LOW_CYC consecutive clock cycles is discarded. A low of exactly MIN_LOW_CYC cycles is accepted. With the bus idle, `sys_rst_o` rises SYNC_STAGES+MIN_LOW_CYC+1 clock edges after the line first goes low.
- R3: `sys_rst_o` and `pin_oe_kill_o` are high together from reset entry until the pull-down stretch ends. Neither is high while idle or while reset entry is held off.
- R4: While `bus_busy_i` stays high, reset entry is held off for BUS_WAIT_CYC cycles after acceptance. With the bus busy throughout, `sys_rst_o` rises SYNC_STAGES+MIN_LOW_CYC+BUS_WAIT_CYC edges after the line goes low, and is low before that.
- R5: If `bus_busy_i` falls during the hold-off, `sys_rst_o` rises on the first clock edge that samples it low.
- R6: `rst_pin_pull_o` (1 = pull the line to 0) stays low while the line is held low externally. It rises on the later of two edges: SYNC_STAGES+1 edges after the external release, or two edges after `sys_rst_o` rose.
- R7: `rst_pin_pull_o` stays high for exactly STRETCH_CYC consecutive cycles. `sys_rst_o` falls on the same edge that it falls.
- R8: A low driven on the line during the pull-down stretch and released before the stretch ends has no effect: the stretch length is unchanged and no new reset follows.
- R9: A low that is still present when the stretch ends is treated as a new request, timed from the first idle cycle. With the bus idle, `sys_rst_o` rises again MIN_LOW_CYC+1 edges after the edge on which `rst_pin_pull_o` fell.
- R10: The line model is open drain. Its level is 0 whenever `rst_pin_pull_o` is 1, so the line reads 0 throughout the stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | Readback of the shared reset line (0 = reset requested) |
| bus_busy_i | input | 1 | High while a bus transfer is in progress |
| rst_pin_pull_o | output | 1 | Pull-down enable for the open-drain reset line |
| sys_rst_o | output | 1 | Internal reset to the rest of the system, active high |
| pin_oe_kill_o | output | 1 | Forces pad output enables off / strobes inactive |

## Verification
The bench keeps SYNC_STAGES=2, MIN_LOW_CYC=4 and STRETCH_CYC=512 at their defaults, so it counts a full 512-cycle stretch edge by edge. It reduces BUS_WAIT_CYC to 16. That keeps the bus-watchdog expiry short, so a run with the bus busy throughout and a run where the bus frees up early both fit in a few dozen cycles. With MIN_LOW_CYC of 4, the reject/accept boundary can be tested with 3- and 4-cycle pulses that sit just above the synchronizer depth.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

   typedef enum logic [2:0] {
      RS_IDLE      = 3'd0,
      RS_HOLDOFF   = 3'd1,
      RS_ENTER     = 3'd2,
      RS_AWAIT_REL = 3'd3,
      RS_STRETCH   = 3'd4
   } rs_state_e;

   // counter width able to hold 0 .. lim-1, never narrower than one bit
   function automatic int unsigned cnt_w(input int unsigned lim);
      return (lim > 1) ? $clog2(lim) : 1;
   endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_stage_chk
      $error("rstpin_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rstpin_tick_cnt.sv
module rstpin_tick_cnt
   import rstpin_pkg::*;
#(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);

   localparam int unsigned   W   = cnt_w(LIMIT);
   localparam logic [W-1:0]  TOP = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   if (LIMIT < 1) begin : g_lim_chk
      $error("rstpin_tick_cnt: LIMIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr_i)   cnt <= '0;
      else if (en_i)    cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
   end

   assign last_o = (cnt == TOP);

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);

endmodule

// File: rtl/rstpin_fsm.sv
module rstpin_fsm
   import rstpin_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_ok_i,
   input  logic      bus_busy_i,
   input  logic      hold_tmo_i,
   input  logic      pin_hi_i,
   input  logic      stretch_done_i,
   output rs_state_e state_o
);

   rs_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         RS_IDLE:      if (req_ok_i)                 st_nx = RS_HOLDOFF;
         RS_HOLDOFF:   if (!bus_busy_i || hold_tmo_i) st_nx = RS_ENTER;
         RS_ENTER:                                   st_nx = RS_AWAIT_REL;
         RS_AWAIT_REL: if (pin_hi_i)                 st_nx = RS_STRETCH;
         RS_STRETCH:   if (stretch_done_i)           st_nx = RS_IDLE;
         default:                                    st_nx = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= RS_IDLE;
      else        st <= st_nx;
   end

   assign state_o = st;

   // R4
   holdoff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RS_HOLDOFF && bus_busy_i && !hold_tmo_i) |=> st == RS_HOLDOFF);

   // R7
   stretch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RS_STRETCH && !stretch_done_i) |=> st == RS_STRETCH);

   // R8
   stretch_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RS_STRETCH) |=> (st == RS_STRETCH || st == RS_IDLE));

endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
   import rstpin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned MIN_LOW_CYC  = 4,
   parameter int unsigned BUS_WAIT_CYC = 64,
   parameter int unsigned STRETCH_CYC  = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_pin_i,
   input  logic bus_busy_i,
   output logic rst_pin_pull_o,
   output logic sys_rst_o,
   output logic pin_oe_kill_o
);

   if (MIN_LOW_CYC <= SYNC_STAGES) begin : g_width_chk
      $error("rstpin_ctrl: MIN_LOW_CYC must exceed SYNC_STAGES");
   end
   if (BUS_WAIT_CYC < 1) begin : g_wait_chk
      $error("rstpin_ctrl: BUS_WAIT_CYC must be at least 1");
   end
   if (STRETCH_CYC < 1) begin : g_stretch_chk
      $error("rstpin_ctrl: STRETCH_CYC must be at least 1");
   end

   logic      pin_s;
   rs_state_e st;
   logic      low_seen, w_last, req_ok;
   logic      in_hold, hold_last;
   logic      in_stretch, stretch_last;
   logic      in_reset;

   rstpin_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rst_pin_i),
      .q_o   (pin_s)
   );

   assign low_seen   = (st == RS_IDLE) && !pin_s;
   assign in_hold    = (st == RS_HOLDOFF);
   assign in_stretch = (st == RS_STRETCH);

   rstpin_tick_cnt #(.LIMIT(MIN_LOW_CYC)) u_width (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!low_seen),
      .en_i   (low_seen),
      .last_o (w_last)
   );

   assign req_ok = low_seen && w_last;

   rstpin_tick_cnt #(.LIMIT(BUS_WAIT_CYC)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!in_hold),
      .en_i   (in_hold),
      .last_o (hold_last)
   );

   rstpin_tick_cnt #(.LIMIT(STRETCH_CYC)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!in_stretch),
      .en_i   (in_stretch),
      .last_o (stretch_last)
   );

   rstpin_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_ok_i       (req_ok),
      .bus_busy_i     (bus_busy_i),
      .hold_tmo_i     (hold_last),
      .pin_hi_i       (pin_s),
      .stretch_done_i (stretch_last),
      .state_o        (st)
   );

   assign in_reset       = (st == RS_ENTER) || (st == RS_AWAIT_REL) || in_stretch;
   assign sys_rst_o      = in_reset;
   assign pin_oe_kill_o  = in_reset;
   assign rst_pin_pull_o = in_stretch;

   // R3
   entry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(st) == RS_HOLDOFF);

   // R6
   pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pin_pull_o) |-> $past(pin_s));

   // R7
   stretch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pin_pull_o) |-> $fell(sys_rst_o));

   // R3
   kill_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pin_pull_o |-> (sys_rst_o && pin_oe_kill_o));

endmodule

// File: tb/test_rstpin_ctrl.sv
`timescale 1ns/1ps
module test_rstpin_ctrl;

   localparam int SYNC = 2;
   localparam int MINW = 4;
   localparam int TMO  = 16;
   localparam int EXT  = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_low = 1'b0;
   logic bus_busy = 1'b0;
   logic pull, sys_rst, kill;
   logic pin_w;

   assign pin_w = ~(ext_low | pull);

   always #4 clk = ~clk;

   rstpin_ctrl #(
      .SYNC_STAGES  (SYNC),
      .MIN_LOW_CYC  (MINW),
      .BUS_WAIT_CYC (TMO),
      .STRETCH_CYC  (EXT)
   ) i_rstpin_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .rst_pin_i      (pin_w),
      .bus_busy_i     (bus_busy),
      .rst_pin_pull_o (pull),
      .sys_rst_o      (sys_rst),
      .pin_oe_kill_o  (kill)
   );

   int ecnt = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int q_rise[$];
   int q_drv[$];
   int q_len[$];
   int t_req, exp_rise, rel_at;

   always @(posedge clk) ecnt <= ecnt + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // scoreboard monitor
   bit prev_rst = 0, prev_pull = 0, bad_kill = 0;
   int run_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sys_rst && !prev_rst) begin
            if (q_rise.size() == 0) chk(1'b0, "R8 unexpected reset entry", ecnt, -1);
            else begin
               int e;
               e = q_rise.pop_front();
               chk(ecnt == e, "R2 R4 R5 R9 reset entry edge", ecnt, e);
               chk(kill == 1'b1, "R3 kill with reset", kill, 1);
            end
         end
         if (pull && !prev_pull) begin
            if (q_drv.size() == 0) chk(1'b0, "R6 unexpected pull", ecnt, -1);
            else begin
               int e;
               e = q_drv.pop_front();
               chk(ecnt == e, "R6 pull start edge", ecnt, e);
            end
            run_len = 0;
            bad_kill = 0;
         end
         if (pull) begin
            run_len++;
            if (!(sys_rst && kill)) bad_kill = 1;
         end
         if (!pull && prev_pull) begin
            int e;
            e = (q_len.size() != 0) ? q_len.pop_front() : -1;
            chk(run_len == e, "R7 stretch length", run_len, e);
            chk(!bad_kill, "R3 reset and kill held in stretch", bad_kill, 0);
            chk(sys_rst == 1'b0, "R7 reset ends with pull", sys_rst, 0);
         end
         prev_rst  = sys_rst;
         prev_pull = pull;
      end
   end

   task automatic start_req(input int lat);
      t_req = ecnt;
      ext_low = 1'b1;
      exp_rise = t_req + lat;
      q_rise.push_back(exp_rise);
      q_len.push_back(EXT);
   endtask

   task automatic release_after_rise();
      int a, b;
      while (!sys_rst) @(negedge clk);
      repeat (2) @(negedge clk);
      ext_low = 1'b0;
      rel_at = ecnt;
      a = rel_at + SYNC + 1;
      b = exp_rise + 2;
      q_drv.push_back((a > b) ? a : b);
   endtask

   task automatic wait_done();
      while (!pull) @(negedge clk);
      while (pull) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ecnt, 0);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(sys_rst == 1'b0 && kill == 1'b0 && pull == 1'b0, "R1 outputs in reset", {sys_rst, kill, pull}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sys_rst == 1'b0, "R1 sys_rst after reset", sys_rst, 0);
      chk(kill == 1'b0,    "R1 kill after reset", kill, 0);
      chk(pull == 1'b0,    "R1 pull after reset", pull, 0);
      chk(pin_w == 1'b1,   "R10 line idles high", pin_w, 1);
      repeat (10) @(negedge clk);

      // R2: idle bus, long request
      start_req(SYNC + MINW + 1);
      release_after_rise();
      repeat (20) @(negedge clk);
      chk(pin_w == 1'b0 && pull == 1'b1, "R10 line low during stretch", pin_w, 0);
      wait_done();

      // R4: bus busy throughout, watchdog expiry
      bus_busy = 1'b1;
      @(negedge clk);
      start_req(SYNC + MINW + TMO);
      repeat (SYNC + MINW + TMO - 2) @(negedge clk);
      chk(sys_rst == 1'b0, "R4 no entry while bus busy", sys_rst, 0);
      release_after_rise();
      bus_busy = 1'b0;
      wait_done();

      // R5: bus frees up during hold-off
      bus_busy = 1'b1;
      @(negedge clk);
      start_req(11);
      while (ecnt != t_req + 10) @(negedge clk);
      chk(sys_rst == 1'b0, "R5 held before bus idle", sys_rst, 0);
      bus_busy = 1'b0;
      release_after_rise();
      wait_done();

      // R2: pulse one cycle short of the minimum
      ext_low = 1'b1;
      repeat (MINW - 1) @(negedge clk);
      ext_low = 1'b0;
      repeat (40) @(negedge clk);
      chk(sys_rst == 1'b0, "R2 short pulse discarded", sys_rst, 0);
      chk(pull == 1'b0,    "R2 short pulse no pull", pull, 0);

      // R2 and R6: pulse of exactly the minimum, released before entry
      begin
         int a, b;
         start_req(SYNC + MINW + 1);
         repeat (MINW) @(negedge clk);
         ext_low = 1'b0;
         rel_at = ecnt;
         a = rel_at + SYNC + 1;
         b = exp_rise + 2;
         q_drv.push_back((a > b) ? a : b);
      end
      wait_done();

      // R8: low pulse inside the stretch is ignored
      start_req(SYNC + MINW + 1);
      release_after_rise();
      while (!pull) @(negedge clk);
      repeat (100) @(negedge clk);
      ext_low = 1'b1;
      repeat (20) @(negedge clk);
      ext_low = 1'b0;
      wait_done();
      repeat (40) @(negedge clk);
      chk(sys_rst == 1'b0, "R8 no reset after ignored pulse", sys_rst, 0);

      // R9: low held across the end of the stretch
      start_req(SYNC + MINW + 1);
      release_after_rise();
      while (!pull) @(negedge clk);
      repeat (100) @(negedge clk);
      ext_low = 1'b1;
      while (pull) @(negedge clk);
      exp_rise = ecnt + MINW + 1;
      q_rise.push_back(exp_rise);
      q_len.push_back(EXT);
      release_after_rise();
      wait_done();

      repeat (20) @(negedge clk);
      chk(q_rise.size() == 0 && q_drv.size() == 0 && q_len.size() == 0,
          "R9 scoreboard drained", q_rise.size() + q_drv.size() + q_len.size(), 0);
      finish_run();
   end

endmodule